// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic 24-bit down-counter for a processor subsystem, programmed through four 32-bit registers on a simple synchronous register port. Software writes a reload value, clears the running count and enables the timer. Each tick, the counter either decrements or, if it already sits at zero, reloads. The step from one to zero sets a sticky flag that clears when read, and it can raise a single-cycle interrupt request.

Ticks come from one of two sources. In core mode, every clock cycle in which the timer is enabled is a tick. In reference mode, a tick happens on each rising edge of a slow external reference input, after that input passes through a synchronizer. A read-only calibration word, fixed by parameters, reports the reload value for a 10 ms period and two qualifier flags.

The register port is a plain control interface, not a data stream. It has no back-pressure. A write takes effect at the clock edge where the write enable is high. Read data appears one cycle after the read enable and is zero in every other cycle.

Top module: `tick_timer`

## Requirements
- R1: Address bits [3:2] select the register: 0 is control/status, 1 is reload, 2 is current value, 3 is calibration. The lower address bits are ignored. Read data is registered and appears in the cycle after the read enable. It reads zero when the read enable is low.
- R2: Control bit 0 enables counting, bit 1 enables the interrupt, and bit 2 selects the reference source (1) or the core clock (0). These bits read back as written. Control bits other than 0, 1, 2 and 16 read as zero.
- R3: Control bit 16 is a flag. It is set when the count steps from 1 to 0, and a read of the control register clears it. That read returns the value from before the clear. If the flag is set in the same cycle as the read, the set wins.
- R4: The reload and current value registers hold bits 23:0 only. Bits 31:24 always read as zero.
- R5: On a tick, a count of zero is replaced by the reload value, and any other count decrements by one. With a nonzero reload value R, the flag events are R+1 ticks apart.
- R6: With a reload value of zero, the count stays at zero, and neither the flag nor the interrupt is raised.
- R7: A write of any value to the current value register sets the count to zero and clears the flag. Both take priority over a tick or a flag set in the same cycle.
- R8: In reference mode, the reference input passes through two flops. A rising edge that is first sampled at clock edge k updates the counter at edge k+2. Apart from such an edge, the counter does not change.
- R9: The interrupt is high for exactly one cycle, the cycle after the edge at which the count stepped from 1 to 0. It is raised only if the interrupt enable bit was set at that edge.
- R10: The calibration word carries the 10 ms reload value in bits 23:0, a value-not-exact flag in bit 30, and a no-reference flag in bit 31. Writes to it have no effect.
- R11: While the enable bit is clear, the count holds its value.
- R12: After reset, all registers read as zero except calibration, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_in | input | 1 | External slow reference, asynchronous |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 32 | Registered read data |
| irq_pulse | output | 1 | Single-cycle interrupt request |

## Verification
The bench uses the default 24-bit counter and a two-flop synchronizer, and sets the calibration parameters to a 10 ms value for a 50 MHz clock with the inexact flag set. With that setup, a fixed calibration pattern can be told apart from reset zeros. The random phase mostly writes reload values below eight, so that wraps, reload-zero parking and writes to the current value that land exactly on the 1-to-0 step all happen within a few thousand cycles. A full-width reload write exercises the top of the 24-bit range.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_CALIB   = 2'd3
  } reg_sel_e;

  localparam int CTL_RUN_BIT   = 0;
  localparam int CTL_IRQE_BIT  = 1;
  localparam int CTL_SRC_BIT   = 2;
  localparam int CTL_ZERO_BIT  = 16;
  localparam int CAL_SKEW_BIT  = 30;
  localparam int CAL_NOREF_BIT = 31;
endpackage

// File: rtl/tick_source.sv
module tick_source #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic use_ref,
  input  logic ref_in,
  output logic tick
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;
  logic         ref_rise;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ref_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[MSB-1:0], ref_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[MSB];
  end

  assign ref_rise = sync_q[MSB] & ~last_q;
  assign tick     = run & (use_ref ? ref_rise : 1'b1);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;
  assign at_zero = (count == '0);
  assign hit     = tick & ~clear & (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (tick)    count <= at_zero ? reload : count - ONE;
  end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int               CNT_W       = 24,
  parameter int               ADDR_W      = 4,
  parameter logic [CNT_W-1:0] CAL_TENMS   = '0,
  parameter logic             CAL_INEXACT = 1'b0,
  parameter logic             CAL_NOREF   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              hit,
  output logic              run,
  output logic              use_ref,
  output logic [CNT_W-1:0]  reload,
  output logic              clear_cur,
  output logic              zero_flag,
  output logic              irq
);
  reg_sel_e    sel;
  logic        irq_en;
  logic        wr_ctrl, wr_reload, rd_ctrl;
  logic [DATA_W-1:0] word;
  logic        unused_bits;

  assign sel       = reg_sel_e'(addr[3:2]);
  assign wr_ctrl   = wr_en & (sel == SEL_CTRL);
  assign wr_reload = wr_en & (sel == SEL_RELOAD);
  assign clear_cur = wr_en & (sel == SEL_CURRENT);
  assign rd_ctrl   = rd_en & (sel == SEL_CTRL);
  assign unused_bits = ^{addr[1:0], wr_data[DATA_W-1:CNT_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      irq_en  <= 1'b0;
      use_ref <= 1'b0;
    end else if (wr_ctrl) begin
      run     <= wr_data[CTL_RUN_BIT];
      irq_en  <= wr_data[CTL_IRQE_BIT];
      use_ref <= wr_data[CTL_SRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload <= '0;
    else if (wr_reload) reload <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         zero_flag <= 1'b0;
    else if (clear_cur) zero_flag <= 1'b0;
    else if (hit)       zero_flag <= 1'b1;
    else if (rd_ctrl)   zero_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit & irq_en;
  end

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_CTRL: begin
        word[CTL_RUN_BIT]  = run;
        word[CTL_IRQE_BIT] = irq_en;
        word[CTL_SRC_BIT]  = use_ref;
        word[CTL_ZERO_BIT] = zero_flag;
      end
      SEL_RELOAD:  word[CNT_W-1:0] = reload;
      SEL_CURRENT: word[CNT_W-1:0] = count;
      SEL_CALIB: begin
        word[CNT_W-1:0]     = CAL_TENMS;
        word[CAL_SKEW_BIT]  = CAL_INEXACT;
        word[CAL_NOREF_BIT] = CAL_NOREF;
      end
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? word : '0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int               CNT_W       = 24,
  parameter int               ADDR_W      = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CAL_TENMS   = CNT_W'(149999),
  parameter logic             CAL_INEXACT = 1'b0,
  parameter logic             CAL_NOREF   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  input  logic              reg_rd_en,
  output logic [31:0]       reg_rd_data,
  output logic              irq_pulse
);
  logic             run, use_ref, tick, hit, clear_cur, zero_flag;
  logic [CNT_W-1:0] reload_q, cnt_q;

  tick_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .run(run), .use_ref(use_ref),
    .ref_in(ref_tick_in), .tick(tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clear_cur),
    .reload(reload_q), .count(cnt_q), .hit(hit)
  );

  tick_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAL_TENMS(CAL_TENMS),
    .CAL_INEXACT(CAL_INEXACT), .CAL_NOREF(CAL_NOREF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr_en),
    .wr_data(reg_wr_data), .rd_en(reg_rd_en), .rd_data(reg_rd_data),
    .count(cnt_q), .hit(hit), .run(run), .use_ref(use_ref),
    .reload(reload_q), .clear_cur(clear_cur), .zero_flag(zero_flag),
    .irq(irq_pulse)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int               CNT_W       = 24,
  parameter int               ADDR_W      = 4,
  parameter logic [CNT_W-1:0] CAL_TENMS   = '0,
  parameter logic             CAL_INEXACT = 1'b0,
  parameter logic             CAL_NOREF   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              run,
  input logic              flag,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       rd_data
);
  logic [1:0]  sel;
  logic [31:0] cal_word;
  assign sel = addr[3:2];
  always_comb begin
    cal_word = '0;
    cal_word[CNT_W-1:0] = CAL_TENMS;
    cal_word[30] = CAL_INEXACT;
    cal_word[31] = CAL_NOREF;
  end

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R9
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0 && $past(count) == CNT_W'(1)));
  // R3
  irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && sel == 2'd2)) |=> $stable(count));
  // R6
  zero_reload_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && reload == '0) |=> count == '0);
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == 2'd1 || sel == 2'd2)) |=> rd_data[31:CNT_W] == '0);
  // R10
  calib_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 2'd3) |=> rd_data == cal_word);
endmodule

bind tick_timer tick_timer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAL_TENMS(CAL_TENMS),
  .CAL_INEXACT(CAL_INEXACT), .CAL_NOREF(CAL_NOREF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_pulse), .count(cnt_q),
  .reload(reload_q), .run(run), .flag(zero_flag), .addr(reg_addr),
  .wr_en(reg_wr_en), .rd_en(reg_rd_en), .rd_data(reg_rd_data)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int          CW    = 24;
  localparam logic [23:0] CAL_T = 24'h07A11F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_timer #(.CAL_TENMS(CAL_T), .CAL_INEXACT(1'b1), .CAL_NOREF(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick_in(ref_in), .reg_addr(addr),
    .reg_wr_en(wr_en), .reg_wr_data(wr_data), .reg_rd_en(rd_en),
    .reg_rd_data(rd_data), .irq_pulse(irq)
  );

  // Reference model built from the requirements
  logic [CW-1:0] m_cur, m_rel;
  logic m_flag, m_en, m_ie, m_src, m_s1, m_s2, m_prev, m_irq;
  logic [31:0] m_rd;

  function automatic logic [31:0] exp_word(input logic [1:0] s);
    logic [31:0] w = '0;
    case (s)
      2'd0: begin w[0] = m_en; w[1] = m_ie; w[2] = m_src; w[16] = m_flag; end
      2'd1: w[CW-1:0] = m_rel;
      2'd2: w[CW-1:0] = m_cur;
      default: w = {1'b0, 1'b1, 6'b0, CAL_T};
    endcase
    return w;
  endfunction

  always @(posedge clk) begin : model
    logic tk, ht, wcur;
    logic [1:0] s;
    cyc++;
    s = addr[3:2];
    if (!rst_n) begin
      m_cur = '0; m_rel = '0; m_flag = 0; m_en = 0; m_ie = 0; m_src = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0; m_rd = '0;
    end else begin
      tk   = m_en && (m_src ? (m_s2 && !m_prev) : 1'b1);
      wcur = wr_en && s == 2'd2;
      ht   = tk && !wcur && m_cur == CW'(1);
      m_rd  = rd_en ? exp_word(s) : 32'h0;
      m_irq = ht && m_ie;
      if (wcur) m_flag = 0;
      else if (ht) m_flag = 1;
      else if (rd_en && s == 2'd0) m_flag = 0;
      if (wcur) m_cur = '0;
      else if (tk) m_cur = (m_cur == '0) ? m_rel : m_cur - CW'(1);
      if (wr_en && s == 2'd0) {m_src, m_ie, m_en} = wr_data[2:0];
      if (wr_en && s == 2'd1) m_rel = wr_data[CW-1:0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ref_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // R9: interrupt compared with the model every cycle
  always @(negedge clk) if (rst_n && !done) check("R9 irq", {31'b0, irq}, {31'b0, m_irq});

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    v = rd_data;
    check(tag, rd_data, m_rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(output int c);
    c = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) begin c = cyc; return; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int c1, c2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    rd(4'h0, "R12 ctrl", v); check("R12 ctrl lit", v, 32'h0);
    rd(4'h4, "R12 reload", v); check("R12 reload lit", v, 32'h0);
    rd(4'h8, "R12 current", v); check("R12 current lit", v, 32'h0);
    check("R12 irq", {31'b0, irq}, 32'h0);

    // R10 calibration word, writes ignored
    rd(4'hC, "R10 calib", v); check("R10 calib lit", v, 32'h4007A11F);
    wr(4'hC, 32'h0);
    rd(4'hD, "R10 calib after write", v); check("R10 calib ignore", v, 32'h4007A11F);

    // R4 upper bits, R7 current write clears, R1 low addr bits ignored
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h7, "R4 reload", v); check("R4 reload lit", v, 32'h00FF_FFFF);
    wr(4'h8, 32'h00AB_CDEF);
    rd(4'h8, "R7 current", v); check("R7 current lit", v, 32'h0);
    @(negedge clk); check("R1 idle rd_data", rd_data, 32'h0);

    // R2 control read-back
    wr(4'h0, 32'hFFFF_FFF8);
    rd(4'h0, "R2 ctrl", v); check("R2 ctrl zero lit", v, 32'h0);
    wr(4'h0, 32'h0000_0005);
    idle(3);
    wr(4'h0, 32'h0);
    rd(4'h0, "R2 ctrl off", v);
    wr(4'h8, 0);

    // R5 period with core clock
    wr(4'h4, 32'd4);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h3);
    wait_irq(c1); wait_irq(c2);
    check("R5 period", c2 - c1, 32'd5);
    // R3 flag read and clear
    rd(4'h0, "R3 flag set", v); check("R3 flag bit", v & 32'h0001_0000, 32'h0001_0000);
    rd(4'h0, "R3 flag cleared", v); check("R3 flag clear lit", v & 32'h0001_0000, 32'h0);

    // R11 hold when disabled
    wr(4'h0, 32'h2);
    rd(4'h8, "R11 cur a", v); idle(5);
    rd(4'h8, "R11 cur b", v2); check("R11 hold", v2, v);

    // R6 reload zero parks at zero
    wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'h0, 32'h3);
    idle(20);
    rd(4'h8, "R6 current", v); check("R6 current lit", v, 32'h0);
    rd(4'h0, "R6 flag", v); check("R6 no flag", v, 32'h3);

    // R8 reference source
    wr(4'h0, 32'h0); wr(4'h4, 32'd2); wr(4'h8, 32'h0); wr(4'h0, 32'h7);
    idle(5);
    rd(4'h8, "R8 no edge", v); check("R8 no edge lit", v, 32'h0);
    @(negedge clk); ref_in = 1;
    @(negedge clk); ref_in = 0;
    idle(3);
    rd(4'h8, "R8 one edge", v); check("R8 one edge lit", v, 32'h2);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 10;
      ref_in = ($urandom % 3) == 0;
      case (op)
        0: wr(4'h0, $urandom & 32'h0001_0007);
        1: wr(4'h4, ($urandom % 16 == 0) ? $urandom : ($urandom % 8));
        2: wr(4'h8, $urandom);
        3: wr(4'hC, $urandom);
        4: rd(4'h0, "R3 rnd ctrl", v);
        5: rd(4'h4, "R4 rnd reload", v);
        6: rd(4'h8, "R5 rnd current", v);
        7: rd(4'hC, "R10 rnd calib", v);
        default: idle(1 + $urandom % 4);
      endcase
    end

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule